// File: doc/BRIEF.md
# Block Address Translation Matcher

This block keeps two banks of block-translation register pairs, one serving instruction fetches and one serving data accesses, with eight entries per bank. Each entry has an upper word that describes a naturally aligned effective block (base, size and which privilege levels may use it) and a lower word that gives the real base of the block. A 32-bit effective address is compared against every entry of the selected bank in parallel. The lowest-numbered entry that matches supplies the physical address. When translation is switched off for the selected side, the address passes through unchanged and is flagged as untranslated. A miss is reported with `hit` low so that a later stage (page-table walk) can take over.

Software reaches the entries through a special-register port addressed by a 10-bit register number. Every accepted write pulses `flush` for one cycle so that downstream translation caches can drop stale entries. The lookup result is available combinationally and is also captured into a result register. A two-state result sequencer drives that register. The state is `RS_IDLE` when no result is pending and `RS_HOLD` when a captured result is presented with `res_valid` high. The transition from `RS_IDLE` to `RS_HOLD` and the self-loop on `RS_HOLD` occur on a clock edge with `lk_req` high. The transition from `RS_HOLD` back to `RS_IDLE` and the self-loop on `RS_IDLE` occur on an edge with `lk_req` low.

Top module: `blk_xlate_top`

## Requirements
- R1: After reset, every register word reads as zero, no entry can hit, `res_valid` is low and `flush` is low.
- R2: A register number is accepted when bits [9:5] are 5'h10 or 5'h11. For an accepted number, bit 3 picks the bank (0 instruction, 1 data), the entry index is {bit 5, bits [2:1]}, bit 0 picks the word (0 upper, 1 lower), and bit 4 is ignored. A write updates only that word, and a read of the same number returns it combinationally.
- R3: A read of a number that is not accepted returns zero. A write to such a number changes no register and raises no `flush`.
- R4: The upper word holds a supervisor-valid bit at bit 1 and a user-valid bit at bit 0. With `priv_user` low only bit 1 is consulted, and with it high only bit 0 is consulted. An entry whose consulted bit is clear never hits.
- R5: The upper word holds the block base in bits [31:17] and an 11-bit length field in bits [12:2]. An entry matches when base equals the effective address masked by bits [31:17] with the length-field bits cleared at positions [27:17]. Bits [31:28] are always compared.
- R6: On a hit, `phys_addr[31:12]` is bits [31:12] of (lower-word bits [31:17] at their positions + page-aligned effective address − block base). `phys_addr[11:0]` equals `eff_addr[11:0]`. Lower-word bits [16:0] do not affect the result.
- R7: When several entries of the selected bank match, the lowest-numbered entry determines the result.
- R8: When the enable of the selected side is low (`xlate_en_i` for `side_data`=0, `xlate_en_d` for `side_data`=1), `phys_addr` equals `eff_addr`, `untrans` is high and `hit` is low. The other side's enable has no effect.
- R9: With translation enabled and no matching entry, `hit` and `untrans` are low and `phys_addr` is zero.
- R10: `flush` is high for exactly the cycle after each clock edge at which an accepted write occurs, and is low otherwise.
- R11: `res_valid` is high in the cycle after an edge with `lk_req` high, and low after an edge with `lk_req` low. `res_hit`, `res_untrans` and `res_paddr` then hold the combinational results from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spr_we | input | 1 | Register write strobe |
| spr_num | input | 10 | Register number |
| spr_wdata | input | 32 | Register write data |
| spr_rdata | output | 32 | Register read data (combinational) |
| priv_user | input | 1 | 1 = user state, 0 = supervisor state |
| xlate_en_i | input | 1 | Translation enable, instruction side |
| xlate_en_d | input | 1 | Translation enable, data side |
| side_data | input | 1 | 0 = instruction bank, 1 = data bank |
| lk_req | input | 1 | Capture the lookup result at this edge |
| eff_addr | input | 32 | Effective address |
| hit | output | 1 | Combinational hit |
| untrans | output | 1 | Combinational untranslated flag |
| phys_addr | output | 32 | Combinational physical address |
| flush | output | 1 | One-cycle pulse after an accepted write |
| res_valid | output | 1 | Registered result strobe |
| res_hit | output | 1 | Registered hit |
| res_untrans | output | 1 | Registered untranslated flag |
| res_paddr | output | 32 | Registered physical address |

## Verification
Lookups are driven with one entry per bank at the smallest block size and with a large block that overlaps a small one. The small-block case separates an offset error from a masking error. The overlap exposes a reversed priority scan. The same address is presented to both banks and in both privilege states, which shows whether the bank select and the validity-bit select are wired the right way round. Register traffic mixes accepted numbers, an aliased number differing only in bit 4, and rejected numbers. A reference model checks readback, `flush` and the registered result on every clock, with `lk_req` driven both in bursts and with gaps so that every sequencer transition occurs.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
    localparam int unsigned SPR_IDX_W = 3;
    localparam int unsigned BLK_LSB   = 17;
    localparam int unsigned BL_LSB    = 2;
    localparam int unsigned BL_W      = 11;
    localparam int unsigned PG_LSB    = 12;
    localparam int unsigned VS_BIT    = 1;
    localparam int unsigned VP_BIT    = 0;

    typedef enum logic {SIDE_INSN = 1'b0, SIDE_DATA = 1'b1} side_e;
    typedef enum logic {WORD_UP = 1'b0, WORD_LO = 1'b1} word_e;
    typedef enum logic {RS_IDLE = 1'b0, RS_HOLD = 1'b1} rstate_e;

    typedef struct packed {
        logic                 ok;
        side_e                side;
        logic [SPR_IDX_W-1:0] idx;
        word_e                word;
    } sprsel_t;

    typedef struct packed {
        logic        hit;
        logic        untrans;
        logic [31:0] pa;
    } xres_t;
endpackage

// File: rtl/blkx_spr_decode.sv
module blkx_spr_decode
    import blkx_pkg::*;
#(
    parameter int unsigned SPRW = 10
) (
    input  logic [SPRW-1:0] num,
    output sprsel_t         sel
);
    localparam logic [4:0] GRP_LO = 5'h10;
    localparam logic [4:0] GRP_HI = 5'h11;

    logic [4:0] grp;
    logic       dec_unused;

    assign grp        = num[9:5];
    assign dec_unused = num[4];

    always_comb begin
        sel.ok   = (grp == GRP_LO) || (grp == GRP_HI);
        sel.side = side_e'(num[3]);
        sel.idx  = {num[5], num[2:1]};
        sel.word = word_e'(num[0]);
    end
endmodule

// File: rtl/blkx_pair_bank.sv
module blkx_pair_bank
    import blkx_pkg::*;
#(
    parameter int unsigned N_ENT = 8,
    parameter int unsigned AW    = 32,
    localparam int unsigned IDX_W = $clog2(N_ENT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           idx,
    input  word_e                      word,
    input  logic [AW-1:0]              wdata,
    output logic [N_ENT-1:0][AW-1:0]   up_q,
    output logic [N_ENT-1:0][AW-1:0]   lo_q
);
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic sel_e;
        assign sel_e = we && (idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                up_q[e] <= '0;
                lo_q[e] <= '0;
            end else if (sel_e) begin
                if (word == WORD_UP) up_q[e] <= wdata;
                else                 lo_q[e] <= wdata;
            end
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(up_q) && $stable(lo_q))); // R2
endmodule

// File: rtl/blkx_entry_cmp.sv
module blkx_entry_cmp
    import blkx_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] up,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] ea,
    input  logic          user,
    output logic          match,
    output logic [AW-1:0] pa
);
    localparam logic [AW-1:0] BLK_FIELD = {{(AW-BLK_LSB){1'b1}}, {BLK_LSB{1'b0}}};
    localparam logic [AW-1:0] PG_FIELD  = {{(AW-PG_LSB){1'b1}}, {PG_LSB{1'b0}}};

    logic          vsel;
    logic [AW-1:0] bl_sh;
    logic [AW-1:0] cmp_mask;
    logic [AW-1:0] bepi;
    logic [AW-1:0] base;

    always_comb begin
        vsel     = user ? up[VP_BIT] : up[VS_BIT];
        bl_sh    = {{(AW-BL_W){1'b0}}, up[BL_LSB +: BL_W]} << BLK_LSB;
        cmp_mask = BLK_FIELD & ~bl_sh;
        bepi     = up & BLK_FIELD;
        match    = vsel && (bepi == (ea & cmp_mask));
        base     = (lo & BLK_FIELD) + ((ea & PG_FIELD) - bepi);
        pa       = {base[AW-1:PG_LSB], ea[PG_LSB-1:0]};
    end
endmodule

// File: rtl/blkx_side_lookup.sv
module blkx_side_lookup
    import blkx_pkg::*;
#(
    parameter int unsigned N_ENT = 8,
    parameter int unsigned AW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_ENT-1:0][AW-1:0] up_q,
    input  logic [N_ENT-1:0][AW-1:0] lo_q,
    input  logic [AW-1:0]            ea,
    input  logic                     user,
    input  logic                     en,
    output xres_t                    res
);
    logic [N_ENT-1:0]         match;
    logic [N_ENT-1:0]         grant;
    logic [N_ENT-1:0][AW-1:0] cand;
    logic [AW-1:0]            pa_sel;

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        blkx_entry_cmp #(.AW(AW)) u_cmp (
            .up    (up_q[e]),
            .lo    (lo_q[e]),
            .ea    (ea),
            .user  (user),
            .match (match[e]),
            .pa    (cand[e])
        );
    end

    assign grant = match & (~match + N_ENT'(1));

    always_comb begin
        pa_sel = '0;
        for (int e = 0; e < N_ENT; e++) begin
            if (grant[e]) pa_sel = pa_sel | cand[e];
        end
    end

    always_comb begin
        if (!en) begin
            res.hit     = 1'b0;
            res.untrans = 1'b1;
            res.pa      = ea;
        end else begin
            res.hit     = |match;
            res.untrans = 1'b0;
            res.pa      = pa_sel;
        end
    end

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((((grant - N_ENT'(1)) & match) == '0) && ((grant & match) == grant))); // R7
endmodule

// File: rtl/blk_xlate_top.sv
module blk_xlate_top
    import blkx_pkg::*;
#(
    parameter int unsigned N_ENT = 8,
    parameter int unsigned AW    = 32,
    parameter int unsigned SPRW  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spr_we,
    input  logic [SPRW-1:0] spr_num,
    input  logic [AW-1:0]   spr_wdata,
    output logic [AW-1:0]   spr_rdata,
    input  logic            priv_user,
    input  logic            xlate_en_i,
    input  logic            xlate_en_d,
    input  logic            side_data,
    input  logic            lk_req,
    input  logic [AW-1:0]   eff_addr,
    output logic            hit,
    output logic            untrans,
    output logic [AW-1:0]   phys_addr,
    output logic            flush,
    output logic            res_valid,
    output logic            res_hit,
    output logic            res_untrans,
    output logic [AW-1:0]   res_paddr
);
    localparam int unsigned N_SIDE = 2;
    localparam int unsigned IDX_W  = $clog2(N_ENT);

    sprsel_t                  sel;
    logic                     wr_ok;
    logic [N_SIDE-1:0]        en_vec;
    logic [N_ENT-1:0][AW-1:0] up_q [N_SIDE];
    logic [N_ENT-1:0][AW-1:0] lo_q [N_SIDE];
    xres_t                    side_res [N_SIDE];
    xres_t                    cur;
    logic                     rd_side;
    logic                     flush_q;
    rstate_e                  state_q, state_d;

    blkx_spr_decode #(.SPRW(SPRW)) u_dec (
        .num (spr_num),
        .sel (sel)
    );

    assign wr_ok  = spr_we && sel.ok;
    assign en_vec = {xlate_en_d, xlate_en_i};

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        logic we_s;
        assign we_s = wr_ok && (sel.side == side_e'(s));

        blkx_pair_bank #(.N_ENT(N_ENT), .AW(AW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_s),
            .idx   (IDX_W'(sel.idx)),
            .word  (sel.word),
            .wdata (spr_wdata),
            .up_q  (up_q[s]),
            .lo_q  (lo_q[s])
        );

        blkx_side_lookup #(.N_ENT(N_ENT), .AW(AW)) u_look (
            .clk   (clk),
            .rst_n (rst_n),
            .up_q  (up_q[s]),
            .lo_q  (lo_q[s]),
            .ea    (eff_addr),
            .user  (priv_user),
            .en    (en_vec[s]),
            .res   (side_res[s])
        );
    end

    // register read port
    assign rd_side = (sel.side == SIDE_DATA);
    always_comb begin
        spr_rdata = '0;
        if (sel.ok) begin
            if (sel.word == WORD_UP) spr_rdata = up_q[rd_side][sel.idx];
            else                     spr_rdata = lo_q[rd_side][sel.idx];
        end
    end

    // combinational lookup outputs
    assign cur       = side_data ? side_res[1] : side_res[0];
    assign hit       = cur.hit;
    assign untrans   = cur.untrans;
    assign phys_addr = cur.pa;

    // flush pulse
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= wr_ok;
    end
    assign flush = flush_q;

    // result sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: state_d = lk_req ? RS_HOLD : RS_IDLE;
            RS_HOLD: state_d = lk_req ? RS_HOLD : RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    // result sequencer: outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit     <= 1'b0;
            res_untrans <= 1'b0;
            res_paddr   <= '0;
        end else if (lk_req) begin
            res_hit     <= cur.hit;
            res_untrans <= cur.untrans;
            res_paddr   <= cur.pa;
        end
    end
    assign res_valid = (state_q == RS_HOLD);

    AST_FLUSH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && sel.ok) |=> flush); // R10
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(spr_we && sel.ok) |=> !flush); // R10
    AST_BADNUM_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && !sel.ok) |=> !flush); // R3
    AST_IDENTITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        untrans |-> (phys_addr == eff_addr && !hit)); // R8
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !untrans) |-> (phys_addr == '0)); // R9
    AST_RES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_valid); // R11
    AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !res_valid); // R11
    AST_RES_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (res_paddr == $past(phys_addr) && res_hit == $past(hit)
                    && res_untrans == $past(untrans))); // R11
endmodule

// File: tb/blk_xlate_top_tb_top.sv
module blk_xlate_top_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spr_we;
    logic [9:0]  spr_num;
    logic [31:0] spr_wdata, spr_rdata;
    logic        priv_user, xlate_en_i, xlate_en_d, side_data, lk_req;
    logic [31:0] eff_addr;
    logic        hit, untrans, flush, res_valid, res_hit, res_untrans;
    logic [31:0] phys_addr, res_paddr;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    logic [31:0] m_up [2][8];
    logic [31:0] m_lo [2][8];

    always #(CLK_P/2) clk = ~clk;

    blk_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .spr_we(spr_we), .spr_num(spr_num),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .priv_user(priv_user),
        .xlate_en_i(xlate_en_i), .xlate_en_d(xlate_en_d), .side_data(side_data),
        .lk_req(lk_req), .eff_addr(eff_addr), .hit(hit), .untrans(untrans),
        .phys_addr(phys_addr), .flush(flush), .res_valid(res_valid),
        .res_hit(res_hit), .res_untrans(res_untrans), .res_paddr(res_paddr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void mdec(input logic [9:0] n, output logic ok,
                                 output int s, output int i, output int w);
        int grp;
        grp = int'(n) / 32;
        ok  = (grp == 16) || (grp == 17);
        s   = n[3] ? 1 : 0;
        i   = (int'(n) / 2) % 4 + (n[5] ? 4 : 0);
        w   = n[0] ? 1 : 0;
    endfunction

    function automatic void mlook(input int s, input logic [31:0] ea, input logic user,
                                  input logic en, output logic h, output logic u,
                                  output logic [31:0] pa);
        h = 1'b0; u = 1'b0; pa = 32'h0;
        if (!en) begin
            u = 1'b1; pa = ea;
            return;
        end
        for (int i = 0; i < 8; i++) begin
            logic [31:0] w, bepi, mask, tmp;
            logic        v;
            w = m_up[s][i];
            v = user ? w[0] : w[1];
            if (!v) continue;
            mask = 32'hFFFE_0000 & ~({21'd0, w[12:2]} << 17);
            bepi = w & 32'hFFFE_0000;
            if (bepi == (ea & mask)) begin
                tmp = (m_lo[s][i] & 32'hFFFE_0000) + ((ea & 32'hFFFF_F000) - bepi);
                pa  = (tmp & 32'hFFFF_F000) | (ea & 32'h0000_0FFF);
                h   = 1'b1;
                return;
            end
        end
    endfunction

    // one clock: inputs already applied after a falling edge
    task automatic cyc();
        logic eh, eu, ok, ef, ev;
        logic [31:0] ep, erd;
        int s, i, w;
        #(CLK_P/4);
        mlook(side_data ? 1 : 0, eff_addr, priv_user,
              side_data ? xlate_en_d : xlate_en_i, eh, eu, ep);
        chk(cur_req, "hit", {31'd0, hit}, {31'd0, eh});
        chk(cur_req, "untrans", {31'd0, untrans}, {31'd0, eu});
        chk(cur_req, "phys_addr", phys_addr, ep);
        mdec(spr_num, ok, s, i, w);
        erd = ok ? (w == 1 ? m_lo[s][i] : m_up[s][i]) : 32'h0;
        chk(ok ? "R2" : "R3", "spr_rdata", spr_rdata, erd);
        ev = lk_req;
        ef = spr_we && ok;
        if (ef) begin
            if (w == 1) m_lo[s][i] = spr_wdata;
            else        m_up[s][i] = spr_wdata;
        end
        @(posedge clk);
        #1;
        chk("R10", "flush", {31'd0, flush}, {31'd0, ef});
        chk("R11", "res_valid", {31'd0, res_valid}, {31'd0, ev});
        if (ev) begin
            chk("R11", "res_hit", {31'd0, res_hit}, {31'd0, eh});
            chk("R11", "res_untrans", {31'd0, res_untrans}, {31'd0, eu});
            chk("R11", "res_paddr", res_paddr, ep);
        end
        @(negedge clk);
    endtask

    task automatic spr_wr(input logic [9:0] n, input logic [31:0] d);
        spr_we = 1'b1; spr_num = n; spr_wdata = d; lk_req = 1'b0;
        cyc();
        spr_we = 1'b0;
    endtask

    task automatic look(input string req, input logic sd, input logic user,
                        input logic [31:0] ea, input logic req_en);
        cur_req = req; side_data = sd; priv_user = user; eff_addr = ea; lk_req = req_en;
        cyc();
        lk_req = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++) begin
                m_up[s][i] = 32'h0; m_lo[s][i] = 32'h0;
            end
        rst_n = 1'b0; spr_we = 1'b0; spr_num = 10'h210; spr_wdata = 32'h0;
        priv_user = 1'b0; xlate_en_i = 1'b1; xlate_en_d = 1'b1; side_data = 1'b0;
        lk_req = 1'b1; eff_addr = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        lk_req = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "res_valid", {31'd0, res_valid}, 32'd0);
        chk("R1", "flush", {31'd0, flush}, 32'd0);
        chk("R1", "spr_rdata", spr_rdata, 32'd0);
        chk("R1", "hit", {31'd0, hit}, 32'd0);
        @(negedge clk);
        look("R1", 1'b1, 1'b0, 32'h0000_0000, 1'b1);

        // R2: program entries on both banks
        spr_wr(10'h210, 32'h1000_0002);  // insn 0 upper, 128K, supervisor only
        spr_wr(10'h211, 32'h0040_0012);  // insn 0 lower, low bits set
        spr_wr(10'h212, 32'h2000_1FFF);  // insn 1 upper, 256M, both levels
        spr_wr(10'h213, 32'h8000_0000);
        spr_wr(10'h214, 32'h2000_0003);  // insn 2 upper, overlaps insn 1
        spr_wr(10'h215, 32'h0300_0000);
        spr_wr(10'h23A, 32'h1000_0002);  // data 5 upper
        spr_wr(10'h23B, 32'h0700_0000);  // data 5 lower
        spr_wr(10'h22E, 32'h4000_001D);  // alias of data 7 via bit 4 clear: 1M, user only
        spr_wr(10'h22F, 32'h0900_0000);
        spr_num = 10'h23E; cur_req = "R2"; cyc();   // read data 7 upper (bit 4 set)
        spr_num = 10'h211; cyc();
        spr_num = 10'h23B; cyc();

        // R3: rejected numbers
        spr_wr(10'h250, 32'hDEAD_BEEF);
        spr_wr(10'h1F0, 32'hCAFE_F00D);
        spr_num = 10'h250; cur_req = "R3"; cyc();
        spr_num = 10'h210; cyc();

        // R4: privilege-level valid bits
        look("R4", 1'b0, 1'b0, 32'h1001_2345, 1'b1);
        look("R4", 1'b0, 1'b1, 32'h1001_2345, 1'b1);
        look("R4", 1'b1, 1'b0, 32'h400F_FFFF, 1'b1);
        look("R4", 1'b1, 1'b1, 32'h400F_FFFF, 1'b1);

        // R5 / R6: sizes and address formation
        look("R5", 1'b0, 1'b0, 32'h1002_0000, 1'b1);
        look("R5", 1'b0, 1'b0, 32'h1001_FFFF, 1'b0);
        look("R5", 1'b1, 1'b1, 32'h4010_0000, 1'b1);
        look("R6", 1'b0, 1'b1, 32'h2ABC_DEF0, 1'b1);
        look("R6", 1'b1, 1'b0, 32'h1001_2345, 1'b1);
        look("R6", 1'b1, 1'b1, 32'h4008_7ABC, 1'b0);

        // R7: overlap, lowest index wins
        look("R7", 1'b0, 1'b0, 32'h2000_1234, 1'b1);
        look("R7", 1'b0, 1'b1, 32'h2001_FFFC, 1'b1);

        // R8: translation off per side
        xlate_en_i = 1'b0;
        look("R8", 1'b0, 1'b0, 32'h1001_2345, 1'b1);
        look("R8", 1'b1, 1'b0, 32'h1001_2345, 1'b1);
        xlate_en_i = 1'b1; xlate_en_d = 1'b0;
        look("R8", 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
        look("R8", 1'b0, 1'b0, 32'h2ABC_DEF0, 1'b1);
        xlate_en_d = 1'b1;

        // R9: misses
        look("R9", 1'b0, 1'b0, 32'h5000_0000, 1'b1);
        look("R9", 1'b1, 1'b0, 32'h2000_0000, 1'b1);

        // R10: write during lookup, then overwrite an entry
        cur_req = "R10"; side_data = 1'b1; priv_user = 1'b0; eff_addr = 32'h1001_2345;
        lk_req = 1'b1; spr_we = 1'b1; spr_num = 10'h23B; spr_wdata = 32'h0A00_0000;
        cyc();
        spr_we = 1'b0; cyc();
        lk_req = 1'b0; spr_num = 10'h23A; cyc();

        // R11: gaps and bursts of capture requests
        for (int k = 0; k < 6; k++) begin
            look("R11", k[0], k[1], 32'h2000_0000 + 32'(k) * 32'h0001_1111, (k % 3) != 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule